// File: doc/BRIEF.md
# Single-Error-Correcting, Double-Error-Detecting Memory Word Guard with Scrub

This block protects 64-bit memory words with eight check bits: seven Hamming bits plus one bit of overall parity, 72 bits stored in all. On the write path it takes a data word and returns the check bits one cycle later. On the read path it takes a stored word with its check bits and the word's address. One cycle later it returns the repaired data and a two-bit classification of what it found.

When a read reveals a single-bit fault and scrubbing is enabled, the block raises a one-cycle write-back request. The request carries the address, the repaired data and freshly computed check bits, so the memory controller can overwrite the faulty location. Two saturating counters tally repaired and unrepairable reads. A synchronous clear input resets them.

Top module: `ecc_scrub_unit`

## Requirements
- R1: One cycle after `wr_valid_i`, `wr_valid_o` is high and `wr_chk_o` holds the check bits. Data bit i occupies the (i+1)-th code position in ascending order from 3 to 71, skipping powers of two. For k in 0..6, `wr_chk_o[k]` is the XOR of the data bits whose position has bit k set. `wr_chk_o[7]` is the XOR of all 64 data bits and those 7 bits.
- R2: A read whose syndrome is zero and whose overall parity holds returns status 2'b00 and the data unchanged. `rd_valid_o` rises one cycle after `rd_valid_i`. The syndrome is the received Hamming bits (`rd_chk_i[6:0]`) XOR those recomputed from the received data.
- R3: A read with one flipped data bit returns status 2'b01 and the original data.
- R4: A read with one flipped Hamming bit (`rd_chk_i[6:0]`) returns status 2'b01 and the data unchanged.
- R5: A read where only the overall parity bit (`rd_chk_i[7]`) is flipped returns status 2'b11 and the data unchanged.
- R6: A read with two flipped bits anywhere in the 72 returns status 2'b10 and the received data unaltered.
- R7: A read with failing overall parity whose syndrome names no existing position (greater than 71) returns status 2'b10 and the received data unaltered.
- R8: `scrub_req_o` pulses together with `rd_valid_o` only when `scrub_en_i` was high with the read and the status is 2'b01 or 2'b11. It then carries the read address on `scrub_addr_o`, the repaired data on `scrub_data_o`, and R1 check bits of that data on `scrub_chk_o`.
- R9: `corr_cnt_o` increments once for each read with status 2'b01 or 2'b11. The new value is visible one cycle after `rd_valid_o`.
- R10: `uncorr_cnt_o` increments once for each read with status 2'b10. The new value is visible one cycle after `rd_valid_o`.
- R11: Each counter holds at 2^CNT_W-1 (15 by default) instead of wrapping.
- R12: `cnt_clr_i` zeroes both counters at the next clock edge, and wins over an increment in that same cycle.
- R13: While `rst` is high at a clock edge, `rd_valid_o`, `wr_valid_o` and `scrub_req_o` go low and both counters go to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid_i | input | 1 | Write word present |
| wr_data_i | input | 64 | Data to encode |
| wr_valid_o | output | 1 | Encoded result present |
| wr_data_o | output | 64 | Encoded data, delayed one cycle |
| wr_chk_o | output | 8 | Check bits for `wr_data_o` |
| rd_valid_i | input | 1 | Read word present |
| rd_addr_i | input | 16 | Address of the read word |
| rd_data_i | input | 64 | Stored data as read |
| rd_chk_i | input | 8 | Stored check bits as read |
| scrub_en_i | input | 1 | Allow write-back for this read |
| rd_valid_o | output | 1 | Decoded result present |
| rd_data_o | output | 64 | Repaired data |
| rd_status_o | output | 2 | 00 clean, 01 repaired, 10 unrepairable, 11 parity bit only |
| scrub_req_o | output | 1 | Write-back request |
| scrub_addr_o | output | 16 | Write-back address |
| scrub_data_o | output | 64 | Write-back data |
| scrub_chk_o | output | 8 | Write-back check bits |
| cnt_clr_i | input | 1 | Synchronous counter clear |
| corr_cnt_o | output | 4 | Saturating count of repaired reads |
| uncorr_cnt_o | output | 4 | Saturating count of unrepairable reads |

## Verification
The read path is tried with clean words of all zeros and all ones and with single flips in the lowest data bit, the highest data bit, a middle data bit, the lowest and highest Hamming bits, and the overall parity bit. This separates data repair from check-bit repair and from the parity-only case. Double flips cover data and data, data and Hamming bit, and data and parity bit, which checks that the parity bit alone does not turn a double into a single. A triple flip whose syndrome points past the last position shows that a failing parity is not enough to claim a repair. Directed runs then cover scrub suppression, counter saturation, a clear that coincides with an increment, and reset in the middle of traffic.

// File: rtl/ecc_scrub_pkg.sv
package ecc_scrub_pkg;

  typedef enum logic [1:0] {
    ST_CLEAN  = 2'b00,
    ST_CORR   = 2'b01,
    ST_UNCORR = 2'b10,
    ST_PAR    = 2'b11
  } ecc_status_e;

  // Smallest Hamming width p with 2^p >= data + p + 1.
  function automatic int ham_bits(input int dw);
    int p;
    p = 1;
    while ((1 << p) < dw + p + 1) p++;
    return p;
  endfunction

  // Code position of data bit idx: ascending, powers of two skipped.
  function automatic int data_pos(input int idx, input int hw);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int q = 1; q < (1 << hw); q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == idx) res = q;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/ecc_hamming_gen.sv
module ecc_hamming_gen
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = ham_bits(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  output logic [HAM_W-1:0]  ham_o
);

  logic [HAM_W-1:0] term [DATA_W];

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_term
    localparam int POS = data_pos(gi, HAM_W);
    assign term[gi] = data_i[gi] ? POS[HAM_W-1:0] : '0;
  end

  always_comb begin
    ham_o = '0;
    for (int i = 0; i < DATA_W; i++) ham_o = ham_o ^ term[i];
  end

endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int HAM_W  = ham_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output logic [HAM_W:0]    chk_o
);

  logic [HAM_W-1:0] ham;

  ecc_hamming_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_gen (
    .data_i (data_i),
    .ham_o  (ham)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      chk_o   <= '0;
    end else begin
      valid_o <= valid_i;
      data_o  <= data_i;
      chk_o   <= {^{data_i, ham}, ham};
    end
  end

  p_wr_follow_r1: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  p_wr_even_r1: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (^{data_o, chk_o}) == 1'b0);

endmodule

// File: rtl/ecc_decoder.sv
module ecc_decoder
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int HAM_W  = ham_bits(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [HAM_W:0]    chk_i,
  input  logic              scrub_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o,
  output ecc_status_e       status_o,
  output logic              scrub_req_o,
  output logic [ADDR_W-1:0] scrub_addr_o,
  output logic [HAM_W:0]    scrub_chk_o
);

  logic [HAM_W-1:0]  ham_rx;
  logic [HAM_W-1:0]  syn;
  logic [HAM_W-1:0]  ham_fix;
  logic [DATA_W-1:0] hit;
  logic [DATA_W-1:0] data_fix;
  logic              par_err;
  logic              any_hit;
  logic              syn_is_chk;
  ecc_status_e       st_nx;

  ecc_hamming_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_gen_rx (
    .data_i (data_i),
    .ham_o  (ham_rx)
  );

  assign syn     = ham_rx ^ chk_i[HAM_W-1:0];
  assign par_err = ^{data_i, chk_i};

  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_hit
    localparam int POS = data_pos(gi, HAM_W);
    assign hit[gi] = (syn == POS[HAM_W-1:0]);
  end

  assign any_hit    = |hit;
  assign syn_is_chk = (syn != '0) && ((syn & (syn - 1'b1)) == '0);

  always_comb begin
    st_nx    = ST_CLEAN;
    data_fix = data_i;
    if (syn == '0) begin
      st_nx = par_err ? ST_PAR : ST_CLEAN;
    end else if (par_err && any_hit) begin
      st_nx    = ST_CORR;
      data_fix = data_i ^ hit;
    end else if (par_err && syn_is_chk) begin
      st_nx = ST_CORR;
    end else begin
      st_nx = ST_UNCORR;
    end
  end

  ecc_hamming_gen #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_gen_fix (
    .data_i (data_fix),
    .ham_o  (ham_fix)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o      <= 1'b0;
      data_o       <= '0;
      status_o     <= ST_CLEAN;
      scrub_req_o  <= 1'b0;
      scrub_addr_o <= '0;
      scrub_chk_o  <= '0;
    end else begin
      valid_o      <= valid_i;
      data_o       <= data_fix;
      status_o     <= st_nx;
      scrub_req_o  <= valid_i && scrub_en_i && (st_nx == ST_CORR || st_nx == ST_PAR);
      scrub_addr_o <= addr_i;
      scrub_chk_o  <= {^{data_fix, ham_fix}, ham_fix};
    end
  end

  p_rd_follow_r2: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  p_clean_keeps_r2: assert property (@(posedge clk) disable iff (rst)
    valid_o && status_o == ST_CLEAN |-> data_o == $past(data_i));

  p_one_flip_r3: assert property (@(posedge clk) disable iff (rst)
    valid_o && status_o == ST_CORR |-> $countones(data_o ^ $past(data_i)) <= 1);

  p_par_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    valid_o && status_o == ST_PAR |-> data_o == $past(data_i));

  p_uncorr_raw_r6: assert property (@(posedge clk) disable iff (rst)
    valid_o && status_o == ST_UNCORR |-> data_o == $past(data_i));

  p_scrub_gate_r8: assert property (@(posedge clk) disable iff (rst)
    scrub_req_o |-> valid_o && (status_o == ST_CORR || status_o == ST_PAR));

  p_scrub_even_r8: assert property (@(posedge clk) disable iff (rst)
    scrub_req_o |-> (^{data_o, scrub_chk_o}) == 1'b0);

endmodule

// File: rtl/ecc_sat_counter.sv
module ecc_sat_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      cnt_o <= '0;
    end else if (inc_i && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  p_step_r9: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> (cnt_o == $past(cnt_o)) || (cnt_o == $past(cnt_o) + 1'b1));

  p_sat_hold_r11: assert property (@(posedge clk) disable iff (rst)
    cnt_o == CNT_MAX && !clr_i |=> cnt_o == CNT_MAX);

  p_clear_r12: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> cnt_o == '0);

endmodule

// File: rtl/ecc_scrub_unit.sv
module ecc_scrub_unit
  import ecc_scrub_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 4,
  localparam int HAM_W = ham_bits(DATA_W),
  localparam int CHK_W = HAM_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              wr_valid_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [CHK_W-1:0]  wr_chk_o,
  input  logic              rd_valid_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [CHK_W-1:0]  rd_chk_i,
  input  logic              scrub_en_i,
  output logic              rd_valid_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [1:0]        rd_status_o,
  output logic              scrub_req_o,
  output logic [ADDR_W-1:0] scrub_addr_o,
  output logic [DATA_W-1:0] scrub_data_o,
  output logic [CHK_W-1:0]  scrub_chk_o,
  input  logic              cnt_clr_i,
  output logic [CNT_W-1:0]  corr_cnt_o,
  output logic [CNT_W-1:0]  uncorr_cnt_o
);

  localparam int N_CNT = 2;

  ecc_status_e      dec_status;
  logic [N_CNT-1:0] evt;
  logic [CNT_W-1:0] cnt [N_CNT];

  ecc_encoder #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_enc (
    .clk     (clk),
    .rst     (rst),
    .valid_i (wr_valid_i),
    .data_i  (wr_data_i),
    .valid_o (wr_valid_o),
    .data_o  (wr_data_o),
    .chk_o   (wr_chk_o)
  );

  ecc_decoder #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .HAM_W(HAM_W)) u_dec (
    .clk          (clk),
    .rst          (rst),
    .valid_i      (rd_valid_i),
    .addr_i       (rd_addr_i),
    .data_i       (rd_data_i),
    .chk_i        (rd_chk_i),
    .scrub_en_i   (scrub_en_i),
    .valid_o      (rd_valid_o),
    .data_o       (rd_data_o),
    .status_o     (dec_status),
    .scrub_req_o  (scrub_req_o),
    .scrub_addr_o (scrub_addr_o),
    .scrub_chk_o  (scrub_chk_o)
  );

  assign rd_status_o  = dec_status;
  assign scrub_data_o = rd_data_o;

  assign evt[0] = rd_valid_o && (dec_status == ST_CORR || dec_status == ST_PAR);
  assign evt[1] = rd_valid_o && (dec_status == ST_UNCORR);

  for (genvar gi = 0; gi < N_CNT; gi++) begin : g_cnt
    ecc_sat_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .clr_i (cnt_clr_i),
      .inc_i (evt[gi]),
      .cnt_o (cnt[gi])
    );
  end

  assign corr_cnt_o   = cnt[0];
  assign uncorr_cnt_o = cnt[1];

  p_reset_quiet_r13: assert property (@(posedge clk)
    rst |=> !rd_valid_o && !wr_valid_o && !scrub_req_o
            && corr_cnt_o == '0 && uncorr_cnt_o == '0);

endmodule

// File: tb/ecc_scrub_unit_tb.sv
`timescale 1ns/1ps
module ecc_scrub_unit_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_valid_i = 1'b0;
  logic [63:0] wr_data_i = '0;
  logic        wr_valid_o;
  logic [63:0] wr_data_o;
  logic [7:0]  wr_chk_o;
  logic        rd_valid_i = 1'b0;
  logic [15:0] rd_addr_i = '0;
  logic [63:0] rd_data_i = '0;
  logic [7:0]  rd_chk_i = '0;
  logic        scrub_en_i = 1'b0;
  logic        rd_valid_o;
  logic [63:0] rd_data_o;
  logic [1:0]  rd_status_o;
  logic        scrub_req_o;
  logic [15:0] scrub_addr_o;
  logic [63:0] scrub_data_o;
  logic [7:0]  scrub_chk_o;
  logic        cnt_clr_i = 1'b0;
  logic [3:0]  corr_cnt_o;
  logic [3:0]  uncorr_cnt_o;

  int checks = 0;
  int failures = 0;
  int exp_corr = 0;
  int exp_uncorr = 0;

  always #2.5 clk = ~clk;

  ecc_scrub_unit u_dut (
    .clk(clk), .rst(rst),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i),
    .wr_valid_o(wr_valid_o), .wr_data_o(wr_data_o), .wr_chk_o(wr_chk_o),
    .rd_valid_i(rd_valid_i), .rd_addr_i(rd_addr_i), .rd_data_i(rd_data_i),
    .rd_chk_i(rd_chk_i), .scrub_en_i(scrub_en_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_status_o(rd_status_o),
    .scrub_req_o(scrub_req_o), .scrub_addr_o(scrub_addr_o),
    .scrub_data_o(scrub_data_o), .scrub_chk_o(scrub_chk_o),
    .cnt_clr_i(cnt_clr_i), .corr_cnt_o(corr_cnt_o), .uncorr_cnt_o(uncorr_cnt_o)
  );

  // {data[63:0], flip mask over {chk,data}[71:0], expected status[1:0]}
  localparam int NV = 12;
  localparam logic [137:0] VEC [NV] = '{
    {64'h0000_0000_0000_0000, 72'h0, 2'b00},
    {64'hFFFF_FFFF_FFFF_FFFF, 72'h0, 2'b00},
    {64'hA5A5_5A5A_0F0F_F0F0, (72'h1 << 0), 2'b01},
    {64'h0123_4567_89AB_CDEF, (72'h1 << 63), 2'b01},
    {64'hDEAD_BEEF_CAFE_F00D, (72'h1 << 64), 2'b01},
    {64'h1111_2222_3333_4444, (72'h1 << 70), 2'b01},
    {64'h8000_0000_0000_0001, (72'h1 << 71), 2'b11},
    {64'h0F1E_2D3C_4B5A_6978, (72'h1 << 5) | (72'h1 << 40), 2'b10},
    {64'h7777_0000_FFFF_1234, (72'h1 << 1) | (72'h1 << 65), 2'b10},
    {64'h0000_FFFF_0000_FFFF, (72'h1 << 10) | (72'h1 << 71), 2'b10},
    {64'h1357_9BDF_2468_ACE0, (72'h1 << 0) | (72'h1 << 67) | (72'h1 << 70), 2'b10},
    {64'hFEDC_BA98_7654_3210, (72'h1 << 32), 2'b01}
  };

  function automatic logic [7:0] tb_enc(input logic [63:0] d);
    logic [6:0] h;
    int pos;
    h = '0;
    pos = 2;
    for (int i = 0; i < 64; i++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      if (d[i]) h = h ^ pos[6:0];
    end
    return {^{d, h}, h};
  endfunction

  function automatic int sat_inc(input int v);
    return (v < 15) ? v + 1 : 15;
  endfunction

  function automatic string req_of(input logic [1:0] st, input logic [71:0] flip);
    if (st == 2'b00) return "R2";
    if (st == 2'b11) return "R5";
    if (st == 2'b01) return (flip[63:0] != '0) ? "R3" : "R4";
    return ($countones(flip) == 3) ? "R7" : "R6";
  endfunction

  task automatic check_eq(input string req, input string what,
                          input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [63:0] d, input logic [71:0] flip,
                         input logic [15:0] addr, input logic sen);
    logic [71:0] cw;
    cw = {tb_enc(d), d} ^ flip;
    @(negedge clk);
    rd_valid_i = 1'b1;
    rd_addr_i  = addr;
    rd_data_i  = cw[63:0];
    rd_chk_i   = cw[71:64];
    scrub_en_i = sen;
    @(negedge clk);
    rd_valid_i = 1'b0;
  endtask

  task automatic note_event(input logic [1:0] st);
    if (st == 2'b01 || st == 2'b11) exp_corr = sat_inc(exp_corr);
    if (st == 2'b10) exp_uncorr = sat_inc(exp_uncorr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R13 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R13 reset state
    check_eq("R13", "rd_valid_o", rd_valid_o, 0);
    check_eq("R13", "wr_valid_o", wr_valid_o, 0);
    check_eq("R13", "scrub_req_o", scrub_req_o, 0);
    check_eq("R13", "corr_cnt_o", corr_cnt_o, 0);
    check_eq("R13", "uncorr_cnt_o", uncorr_cnt_o, 0);

    for (int v = 0; v < NV; v++) begin
      logic [63:0] d;
      logic [71:0] flip;
      logic [1:0]  st;
      logic [63:0] exp_data;
      logic        exp_req;
      string       rq;
      d    = VEC[v][137:74];
      flip = VEC[v][73:2];
      st   = VEC[v][1:0];
      rq   = req_of(st, flip);
      exp_data = (st == 2'b10) ? (d ^ flip[63:0]) : d;
      exp_req  = (st == 2'b01) || (st == 2'b11);

      // R1 encode path
      @(negedge clk);
      wr_valid_i = 1'b1;
      wr_data_i  = d;
      @(negedge clk);
      wr_valid_i = 1'b0;
      check_eq("R1", "wr_valid_o", wr_valid_o, 1);
      check_eq("R1", "wr_chk_o", wr_chk_o, tb_enc(d));
      check_eq("R1", "wr_data_o", wr_data_o, d);

      do_read(d, flip, 16'(v), 1'b1);
      check_eq("R2", "rd_valid_o", rd_valid_o, 1);
      check_eq(rq, "rd_status_o", rd_status_o, st);
      check_eq(rq, "rd_data_o", rd_data_o, exp_data);
      check_eq("R8", "scrub_req_o", scrub_req_o, exp_req);
      if (exp_req) begin
        check_eq("R8", "scrub_addr_o", scrub_addr_o, 16'(v));
        check_eq("R8", "scrub_data_o", scrub_data_o, d);
        check_eq("R8", "scrub_chk_o", scrub_chk_o, tb_enc(d));
      end
      note_event(st);
      @(negedge clk);
      check_eq("R9", "corr_cnt_o", corr_cnt_o, 4'(exp_corr));
      check_eq("R10", "uncorr_cnt_o", uncorr_cnt_o, 4'(exp_uncorr));
    end

    // R8: scrub disabled suppresses the request on a repaired read
    do_read(64'h0BAD_F00D_1234_5678, (72'h1 << 7), 16'h0055, 1'b0);
    check_eq("R3", "rd_status_o no-scrub", rd_status_o, 2'b01);
    check_eq("R8", "scrub_req_o disabled", scrub_req_o, 0);
    note_event(2'b01);
    @(negedge clk);
    check_eq("R9", "corr_cnt_o after no-scrub", corr_cnt_o, 4'(exp_corr));

    // R11: saturation
    for (int k = 0; k < 20; k++) begin
      do_read(64'(k) * 64'h0101_0101_0101_0101, (72'h1 << (k + 20)), 16'(k), 1'b1);
      note_event(2'b01);
    end
    @(negedge clk);
    check_eq("R11", "corr_cnt_o saturated", corr_cnt_o, 4'd15);
    for (int k = 0; k < 14; k++) begin
      do_read(64'h5555_AAAA_5555_AAAA, (72'h1 << 2) | (72'h1 << (k + 30)), 16'(k), 1'b0);
      note_event(2'b10);
    end
    @(negedge clk);
    check_eq("R11", "uncorr_cnt_o saturated", uncorr_cnt_o, 4'd15);

    // R12: clear coincides with an increment and wins
    do_read(64'h2222_4444_6666_8888, (72'h1 << 9), 16'h0001, 1'b1);
    cnt_clr_i = 1'b1;
    @(negedge clk);
    cnt_clr_i = 1'b0;
    check_eq("R12", "corr_cnt_o cleared", corr_cnt_o, 0);
    check_eq("R12", "uncorr_cnt_o cleared", uncorr_cnt_o, 0);
    do_read(64'h2222_4444_6666_8888, (72'h1 << 66), 16'h0002, 1'b1);
    @(negedge clk);
    check_eq("R9", "corr_cnt_o after clear", corr_cnt_o, 1);

    // R13: reset in mid traffic
    do_read(64'h3333_0000_3333_0000, (72'h1 << 3) | (72'h1 << 4), 16'h0003, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    check_eq("R13", "rd_valid_o in reset", rd_valid_o, 0);
    check_eq("R13", "corr_cnt_o in reset", corr_cnt_o, 0);
    check_eq("R13", "uncorr_cnt_o in reset", uncorr_cnt_o, 0);
    rst = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule